// File: doc/BRIEF.md
# Half-Buffer Audio Playback Controller

This block streams stereo audio out of a 2 KB sample ring held in an external synchronous memory. Each pulse on the sample-tick input fetches one stereo pair (two signed 16-bit channels in a 32-bit word) at the playback pointer. The block scales both channels by an 8-bit volume, presents them as DAC words and advances the pointer. The pointer's top bit is exported as a half flag. A host watches that flag and, each time it toggles, refills the half of the ring that is no longer being played.

Play, pause and pointer-rewind strobes steer playback. While playback is stopped the DAC words sit at zero. The block also keeps a 16-bit status word for the host. Its low byte carries track-request, data-request and control-change flags raised by the requesting side, and the host acknowledges them with set and clear masks. Its high byte carries the audio half flag and a data-buffer half flag fed in from outside.

Top module: `halfbuf_player`

## Requirements
- R1: After a synchronous active-low reset, `status` is 0, both sample outputs are 0, `smp_valid` is 0, `mem_addr` is 0 and playback is stopped.
- R2: While playing, each cycle with `tick` high advances `mem_addr` (the word address, pointer bits 10:2) by one. It wraps from 511 to 0.
- R3: While stopped, `tick` has no effect: `mem_addr` holds and `smp_valid` stays low.
- R4: `ptr_rst_stb` sets `mem_addr` to 0 on the next edge and takes priority over a `tick` in the same cycle.
- R5: `status[14]` is 1 exactly while the pointer lies in the upper 1 KB half of the ring (word addresses 256 to 511).
- R6: For a tick at word address A, `mem_data` is read with one cycle of latency. Bits 31:16 are the left channel and bits 15:0 the right channel. Two edges after the tick edge, `smp_left` and `smp_right` hold (channel × volume) >>> 8, with the channel signed and the volume unsigned, and `smp_valid` is high for that one cycle.
- R7: From the second edge after a `pause_stb`, both sample outputs are 0. `play_stb` restarts playback. `pause_stb` wins if both are given together.
- R8: A cycle with `stat_we` high updates status bits 7:0 to (old & ~`stat_clr`) | `stat_set`, so a bit both set and cleared ends up set.
- R9: `trk_req` sets status bit 5 and `dat_req` sets bit 4. `ctl_req` sets bit 0 and loads bit 1 from `ctl_play` and bit 2 from `ctl_repeat`. These events override a host clear in the same cycle.
- R10: `status[13]` follows `data_half` one cycle late. Status bits 15 and 12:8 are always 0.
- R11: The volume changes only in a cycle with `vol_we` high. `vol_in` is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample-rate pulse |
| play_stb | input | 1 | Start or resume playback |
| pause_stb | input | 1 | Stop playback, freeze pointer |
| ptr_rst_stb | input | 1 | Rewind pointer to 0 |
| vol_we | input | 1 | Load volume |
| vol_in | input | 8 | Volume value |
| mem_addr | output | 9 | Word address into the sample ring |
| mem_data | input | 32 | Read data, one cycle after address |
| smp_left | output | 16 | Scaled left sample |
| smp_right | output | 16 | Scaled right sample |
| smp_valid | output | 1 | New sample pulse |
| stat_we | input | 1 | Host status update |
| stat_set | input | 8 | Bits to set in status low byte |
| stat_clr | input | 8 | Bits to clear in status low byte |
| trk_req | input | 1 | Audio track request event |
| dat_req | input | 1 | Data request event |
| ctl_req | input | 1 | Control change event |
| ctl_play | input | 1 | Play flag carried by control event |
| ctl_repeat | input | 1 | Repeat flag carried by control event |
| data_half | input | 1 | Data buffer half indicator |
| status | output | 16 | Status word |

## Verification
The pointer assertions assume each strobe is one cycle wide. They also assume the memory answers one cycle after `mem_addr`, and that a pause never lands in the cycle between a tick and its sample load. The stimulus meets these assumptions by driving every strobe for one cycle on the falling edge. It never pauses while a fetch is outstanding, and a one-cycle registered memory model in the bench supplies the read data. Events and host masks are applied together on purpose, to exercise the override order.

// File: rtl/hbp_pkg.sv
// Shared definitions for the half-buffer audio playback controller.
// Holds the status-word bit positions used by the status register and checker.
package hbp_pkg;
    localparam int ST_CTRL   = 0;  // control change pending
    localparam int ST_PLAY   = 1;  // play flag from control event
    localparam int ST_REPEAT = 2;  // repeat flag from control event
    localparam int ST_DREQ   = 4;  // data request pending
    localparam int ST_TREQ   = 5;  // track request pending
    localparam int ST_DHALF  = 13; // data buffer half
    localparam int ST_AHALF  = 14; // audio buffer half
endpackage

// File: rtl/hbp_pointer.sv
// Playback pointer and play state.
// Assumes BUF_BYTES and STEP_BYTES are powers of two, so wrapping is a plain overflow.
module hbp_pointer #(
    parameter int BUF_BYTES  = 2048,
    parameter int STEP_BYTES = 4,
    localparam int ADDR_W    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              play_stb,
    input  logic              pause_stb,
    input  logic              ptr_rst_stb,
    output logic              playing,
    output logic              fetch,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    // Play state: pause beats play.
    always_ff @(posedge clk) begin
        if (!rst_n)         playing <= 1'b0;
        else if (pause_stb) playing <= 1'b0;
        else if (play_stb)  playing <= 1'b1;
    end

    // Pointer: rewind beats advance, advance only while playing.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= '0;
        else if (ptr_rst_stb)      ptr <= '0;
        else if (tick && playing)  ptr <= ptr + STEP;
    end

    // Fetch marker: memory data for the pre-advance address arrives next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch <= 1'b0;
        else        fetch <= tick && playing;
    end
endmodule

// File: rtl/hbp_scale.sv
// Volume register and per-channel scaling of fetched stereo words.
// Assumes mem_data is valid during the cycle in which fetch is high.
module hbp_scale #(
    parameter int SAMPLE_W = 16,
    parameter int VOL_W    = 8,
    parameter int CHANS    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      playing,
    input  logic                      fetch,
    input  logic                      vol_we,
    input  logic [VOL_W-1:0]          vol_in,
    input  logic [CHANS*SAMPLE_W-1:0] mem_data,
    output logic [CHANS*SAMPLE_W-1:0] smp_out,
    output logic                      smp_valid
);
    localparam int PROD_W = SAMPLE_W + VOL_W + 1;

    logic [VOL_W-1:0] vol_q;

    // Volume holds unless explicitly written.
    always_ff @(posedge clk) begin
        if (!rst_n)      vol_q <= '0;
        else if (vol_we) vol_q <= vol_in;
    end

    // Valid pulse for each sample loaded during playback.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_valid <= 1'b0;
        else        smp_valid <= playing && fetch;
    end

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        logic [SAMPLE_W-1:0]      raw;
        logic signed [PROD_W-1:0] prod;

        assign raw  = mem_data[c*SAMPLE_W +: SAMPLE_W];
        // Signed sample times unsigned volume, both widened to the product width.
        assign prod = $signed({{(VOL_W+1){raw[SAMPLE_W-1]}}, raw})
                    * $signed({{(SAMPLE_W+1){1'b0}}, vol_q});

        // Output word: zero while stopped, scaled sample on fetch, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n || !playing) smp_out[c*SAMPLE_W +: SAMPLE_W] <= '0;
            else if (fetch)         smp_out[c*SAMPLE_W +: SAMPLE_W] <= prod[VOL_W +: SAMPLE_W];
        end
    end
endmodule

// File: rtl/hbp_status.sv
// Host status word: low byte of event flags with host set/clear masks,
// high byte of buffer half indicators. Events override a same-cycle host clear.
module hbp_status
    import hbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stat_we,
    input  logic [7:0]  stat_set,
    input  logic [7:0]  stat_clr,
    input  logic        trk_req,
    input  logic        dat_req,
    input  logic        ctl_req,
    input  logic        ctl_play,
    input  logic        ctl_repeat,
    input  logic        data_half,
    input  logic        audio_half,
    output logic [15:0] status
);
    logic [7:0] lo_q, lo_host, lo_next;
    logic       dhalf_q;

    // Host mask update: clear first, then set.
    always_comb begin
        lo_host = lo_q;
        if (stat_we) lo_host = (lo_q & ~stat_clr) | stat_set;
    end

    // Requesting-side events applied on top of the host update.
    always_comb begin
        lo_next = lo_host;
        if (trk_req) lo_next[ST_TREQ] = 1'b1;
        if (dat_req) lo_next[ST_DREQ] = 1'b1;
        if (ctl_req) begin
            lo_next[ST_CTRL]   = 1'b1;
            lo_next[ST_PLAY]   = ctl_play;
            lo_next[ST_REPEAT] = ctl_repeat;
        end
    end

    // Low byte and data-half register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            dhalf_q <= 1'b0;
        end else begin
            lo_q    <= lo_next;
            dhalf_q <= data_half;
        end
    end

    // Status word assembly.
    always_comb begin
        status           = '0;
        status[7:0]      = lo_q;
        status[ST_DHALF] = dhalf_q;
        status[ST_AHALF] = audio_half;
    end
endmodule

// File: rtl/halfbuf_player.sv
// Top level of the half-buffer audio playback controller.
// Assumes an external synchronous sample memory with one cycle of read latency.
module halfbuf_player #(
    parameter int BUF_BYTES = 2048,
    parameter int SAMPLE_W  = 16,
    parameter int VOL_W     = 8,
    localparam int CHANS      = 2,
    localparam int STEP_BYTES = CHANS * SAMPLE_W / 8,
    localparam int ADDR_W     = $clog2(BUF_BYTES),
    localparam int WADDR_W    = ADDR_W - $clog2(STEP_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      play_stb,
    input  logic                      pause_stb,
    input  logic                      ptr_rst_stb,
    input  logic                      vol_we,
    input  logic [VOL_W-1:0]          vol_in,
    output logic [WADDR_W-1:0]        mem_addr,
    input  logic [CHANS*SAMPLE_W-1:0] mem_data,
    output logic [SAMPLE_W-1:0]       smp_left,
    output logic [SAMPLE_W-1:0]       smp_right,
    output logic                      smp_valid,
    input  logic                      stat_we,
    input  logic [7:0]                stat_set,
    input  logic [7:0]                stat_clr,
    input  logic                      trk_req,
    input  logic                      dat_req,
    input  logic                      ctl_req,
    input  logic                      ctl_play,
    input  logic                      ctl_repeat,
    input  logic                      data_half,
    output logic [15:0]               status
);
    logic                      playing_w, fetch_w;
    logic [ADDR_W-1:0]         ptr_w;
    logic [CHANS*SAMPLE_W-1:0] smp_w;

    hbp_pointer #(.BUF_BYTES(BUF_BYTES), .STEP_BYTES(STEP_BYTES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .play_stb(play_stb),
        .pause_stb(pause_stb), .ptr_rst_stb(ptr_rst_stb),
        .playing(playing_w), .fetch(fetch_w), .ptr(ptr_w)
    );

    hbp_scale #(.SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W), .CHANS(CHANS)) u_scale (
        .clk(clk), .rst_n(rst_n), .playing(playing_w), .fetch(fetch_w),
        .vol_we(vol_we), .vol_in(vol_in), .mem_data(mem_data),
        .smp_out(smp_w), .smp_valid(smp_valid)
    );

    hbp_status u_stat (
        .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_set(stat_set),
        .stat_clr(stat_clr), .trk_req(trk_req), .dat_req(dat_req),
        .ctl_req(ctl_req), .ctl_play(ctl_play), .ctl_repeat(ctl_repeat),
        .data_half(data_half), .audio_half(ptr_w[ADDR_W-1]), .status(status)
    );

    assign mem_addr  = ptr_w[ADDR_W-1 -: WADDR_W];
    assign smp_right = smp_w[0 +: SAMPLE_W];
    assign smp_left  = smp_w[SAMPLE_W +: SAMPLE_W];
endmodule

// File: rtl/halfbuf_player_chk.sv
// Property checker for the half-buffer audio playback controller, bound to the top.
module halfbuf_player_chk #(
    parameter int WADDR_W  = 9,
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                ptr_rst_stb,
    input logic                playing,
    input logic [WADDR_W-1:0]  mem_addr,
    input logic [SAMPLE_W-1:0] smp_left,
    input logic [SAMPLE_W-1:0] smp_right,
    input logic                smp_valid,
    input logic                trk_req,
    input logic                dat_req,
    input logic                data_half,
    input logic [15:0]         status
);
    // R2: a tick during playback moves the word address by one
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (playing && tick && !ptr_rst_stb) |=> mem_addr == $past(mem_addr) + 1'b1);

    // R3: stopped playback freezes the pointer
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!playing && !ptr_rst_stb) |=> $stable(mem_addr));

    // R4: rewind lands on zero
    a_r4_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst_stb |=> mem_addr == '0);

    // R7: outputs silent one edge after playback is stopped
    a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !playing |=> (smp_left == '0 && smp_right == '0 && !smp_valid));

    // R9: request events always reach the status word
    a_r9_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_req && dat_req) |=> (status[5] && status[4]));

    // R10: data half mirrored one cycle late
    a_r10_dhalf: assert property (@(posedge clk) disable iff (!rst_n)
        data_half |=> status[13]);
endmodule

bind halfbuf_player halfbuf_player_chk #(.WADDR_W(WADDR_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ptr_rst_stb(ptr_rst_stb),
    .playing(playing_w), .mem_addr(mem_addr), .smp_left(smp_left),
    .smp_right(smp_right), .smp_valid(smp_valid), .trk_req(trk_req),
    .dat_req(dat_req), .data_half(data_half), .status(status)
);

// File: tb/halfbuf_player_test.sv
`timescale 1ns/1ps
module halfbuf_player_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, play_stb = 1'b0, pause_stb = 1'b0, ptr_rst_stb = 1'b0;
    logic        vol_we = 1'b0;
    logic [7:0]  vol_in = '0;
    logic [8:0]  mem_addr;
    logic [31:0] mem_data;
    logic [15:0] smp_left, smp_right, status;
    logic        smp_valid;
    logic        stat_we = 1'b0;
    logic [7:0]  stat_set = '0, stat_clr = '0;
    logic        trk_req = 1'b0, dat_req = 1'b0, ctl_req = 1'b0;
    logic        ctl_play = 1'b0, ctl_repeat = 1'b0, data_half = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [31:0] bmem [512];

    always #2 clk = ~clk;

    // Synchronous memory model, one cycle of read latency.
    always @(posedge clk) mem_data <= bmem[mem_addr];

    halfbuf_player uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .play_stb(play_stb),
        .pause_stb(pause_stb), .ptr_rst_stb(ptr_rst_stb), .vol_we(vol_we),
        .vol_in(vol_in), .mem_addr(mem_addr), .mem_data(mem_data),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .stat_we(stat_we), .stat_set(stat_set), .stat_clr(stat_clr),
        .trk_req(trk_req), .dat_req(dat_req), .ctl_req(ctl_req),
        .ctl_play(ctl_play), .ctl_repeat(ctl_repeat), .data_half(data_half),
        .status(status)
    );

    // {left, right, volume, expected left, expected right}
    localparam logic [71:0] VEC [5] = '{
        {16'h7FFF, 16'h8000, 8'hFF, 16'h7F7F, 16'h8080},
        {16'h0100, 16'hFFFF, 8'h01, 16'h0001, 16'hFFFF},
        {16'h1234, 16'hEDCC, 8'h00, 16'h0000, 16'h0000},
        {16'h0003, 16'hFFFD, 8'h40, 16'h0000, 16'hFFFF},
        {16'h4000, 16'hC000, 8'h80, 16'h2000, 16'hE000}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic pulse_tick_and_wait();
        tick = 1'b1; step(); tick = 1'b0; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) bmem[i] = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 samples", {smp_left, smp_right}, 32'h0);
        chk("R1 valid", 32'(smp_valid), 32'h0);
        chk("R1 addr", 32'(mem_addr), 32'h0);

        play_stb = 1'b1; step(); play_stb = 1'b0;

        // R6 and R11: vector table walked one tick per entry
        for (int k = 0; k < 5; k++) begin
            bmem[k] = VEC[k][71:40];
            vol_in = VEC[k][39:32]; vol_we = 1'b1; step(); vol_we = 1'b0;
            pulse_tick_and_wait();
            chk("R6 left", 32'(smp_left), 32'(VEC[k][31:16]));
            chk("R6 right", 32'(smp_right), 32'(VEC[k][15:0]));
            chk("R6 valid", 32'(smp_valid), 32'h1);
            chk("R2 addr", 32'(mem_addr), 32'(k + 1));
        end

        // R7: pause silences output on the second edge
        pause_stb = 1'b1; step(); pause_stb = 1'b0; step();
        chk("R7 silent", {smp_left, smp_right}, 32'h0);

        // R3: ticks while stopped are ignored
        for (int k = 0; k < 3; k++) begin
            pulse_tick_and_wait();
            chk("R3 addr", 32'(mem_addr), 32'd5);
            chk("R3 valid", 32'(smp_valid), 32'h0);
        end

        // R4: rewind beats a simultaneous tick
        play_stb = 1'b1; step(); play_stb = 1'b0;
        ptr_rst_stb = 1'b1; tick = 1'b1; step();
        ptr_rst_stb = 1'b0; tick = 1'b0;
        chk("R4 addr", 32'(mem_addr), 32'h0);

        // R5: half flag across the ring
        chk("R5 lower", 32'(status[14]), 32'h0);
        tick = 1'b1; repeat (255) step();
        tick = 1'b0;
        chk("R5 last lower", 32'(status[14]), 32'h0);
        tick = 1'b1; step(); tick = 1'b0;
        chk("R5 upper", 32'(status[14]), 32'h1);
        chk("R2 mid", 32'(mem_addr), 32'd256);
        tick = 1'b1; repeat (255) step(); tick = 1'b0;
        chk("R5 top", 32'(status[14]), 32'h1);
        chk("R2 top", 32'(mem_addr), 32'd511);
        tick = 1'b1; step(); tick = 1'b0;
        chk("R5 wrap", 32'(status[14]), 32'h0);
        chk("R2 wrap", 32'(mem_addr), 32'h0);
        step();

        // R11: volume input ignored without write enable (volume stays 0x80)
        bmem[0] = {16'h0200, 16'hFE00};
        vol_in = 8'h00;
        pulse_tick_and_wait();
        chk("R11 left", 32'(smp_left), 32'h0100);
        chk("R11 right", 32'(smp_right), 32'hFF00);

        // R8: host masks
        stat_we = 1'b1; stat_set = 8'h2C; stat_clr = 8'h00; step();
        chk("R8 set", 32'(status[7:0]), 32'h2C);
        stat_set = 8'h01; stat_clr = 8'h0C; step();
        chk("R8 clr", 32'(status[7:0]), 32'h21);
        stat_set = 8'h80; stat_clr = 8'h80; step();
        chk("R8 both", 32'(status[7:0]), 32'hA1);

        // R9: events override a same-cycle clear
        stat_set = 8'h00; stat_clr = 8'hFF; trk_req = 1'b1; dat_req = 1'b1; step();
        stat_we = 1'b0; trk_req = 1'b0; dat_req = 1'b0;
        chk("R9 requests", 32'(status[7:0]), 32'h30);
        ctl_req = 1'b1; ctl_play = 1'b1; ctl_repeat = 1'b0; step();
        chk("R9 ctl play", 32'(status[7:0]), 32'h33);
        ctl_play = 1'b0; ctl_repeat = 1'b1; step();
        ctl_req = 1'b0;
        chk("R9 ctl repeat", 32'(status[7:0]), 32'h35);

        // R10: data half mirror and zero high bits
        data_half = 1'b1; step();
        chk("R10 set", 32'(status), 32'h2035);
        data_half = 1'b0; step();
        chk("R10 clear", 32'(status), 32'h0035);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule